// File: doc/BRIEF.md
# Interrupt Pending-State Tracker

This block holds the per-line state of a bank of `N` interrupt lines: the last sampled input level, an enable bit, a pending bit and a two-bit configuration (handling model and trigger type). Every clock it merges input sampling, enable and pending writes, configuration writes, acknowledge events and end-of-interrupt events into new enable and pending vectors. A priority selector downstream reads these vectors.

Write requests come in as a valid strobe plus a line bitmap. Acknowledge and end-of-interrupt each come in as a strobe plus an interrupt ID. An ID that names no line (for example 1023) leaves every line unchanged. Lines 0 to 15 are permanently enabled and edge-triggered. Lines 0 to 31 can never be made level-triggered.

Top module: `irq_pend_track`

## Requirements
- R1: After reset, enable and edge bits are 1 for lines 0 to 15 and 0 for all other lines. All pending and model bits are 0.
- R2: When the sampled input of an edge-triggered line goes from 0 to 1, the line becomes pending, whether it is enabled or not.
- R3: When the sampled input of a level-triggered line goes from 0 to 1, the line becomes pending only if it is enabled.
- R4: A sample equal to the stored level changes nothing. A 1-to-0 transition only updates the stored level and never clears pending.
- R5: A set-enable of a level-triggered line whose stored level is 1 also makes that line pending.
- R6: An end-of-interrupt for a level-triggered line that is enabled and whose stored level is still 1 makes it pending again. For any other line it has no effect.
- R7: A configuration write applies `cfg_wr_val` to every masked line, with bit 0 = model and bit 1 = edge trigger. Lines below 32 always keep edge = 1.
- R8: Set-enable and clear-enable writes have no effect on lines 0 to 15.
- R9: An acknowledge clears the pending bit of its ID, whether the line is edge- or level-triggered.
- R10: A set-pending write sets every masked pending bit. A clear-pending write clears every masked pending bit.
- R11: Updates in the same cycle are applied in this order: acknowledge clear, then writes, then input sampling. Any set overrides any clear in that cycle, and conditions use the enable and edge values after that cycle's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N | Raw interrupt input levels |
| en_set_vld | input | 1 | Set-enable strobe |
| en_set_mask | input | N | Lines to enable |
| en_clr_vld | input | 1 | Clear-enable strobe |
| en_clr_mask | input | N | Lines to disable |
| pend_set_vld | input | 1 | Set-pending strobe |
| pend_set_mask | input | N | Lines to make pending |
| pend_clr_vld | input | 1 | Clear-pending strobe |
| pend_clr_mask | input | N | Lines to clear |
| cfg_wr_vld | input | 1 | Configuration write strobe |
| cfg_wr_mask | input | N | Lines to configure |
| cfg_wr_val | input | 2 | Bit 0 model, bit 1 edge |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Acknowledged ID |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Completed ID |
| en_vec | output | N | Enable bits |
| pend_vec | output | N | Pending bits |
| edge_vec | output | N | Edge-trigger bits |
| model_vec | output | N | Model bits |

## Verification
The hardest state to reach is a level-triggered line whose stored level is high while it is disabled and not pending, which is the state R5 and R6 depend on. Directed steps build it in order: configure the line as level-triggered, raise it while it is disabled, then enable it or acknowledge it and send its end-of-interrupt. Random cycles then mix every strobe, including collisions on the same line, against a bench model.

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int N    = 64,
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_in,
  input  logic            en_set_vld,
  input  logic [N-1:0]    en_set_mask,
  input  logic            en_clr_vld,
  input  logic [N-1:0]    en_clr_mask,
  input  logic            pend_set_vld,
  input  logic [N-1:0]    pend_set_mask,
  input  logic            pend_clr_vld,
  input  logic [N-1:0]    pend_clr_mask,
  input  logic            cfg_wr_vld,
  input  logic [N-1:0]    cfg_wr_mask,
  input  logic [1:0]      cfg_wr_val,
  input  logic            ack_vld,
  input  logic [ID_W-1:0] ack_id,
  input  logic            eoi_vld,
  input  logic [ID_W-1:0] eoi_id,
  output logic [N-1:0]    en_vec,
  output logic [N-1:0]    pend_vec,
  output logic [N-1:0]    edge_vec,
  output logic [N-1:0]    model_vec
);
  localparam logic [N-1:0] FIXED = N'(32'h0000_FFFF);
  localparam logic [N-1:0] LOW32 = N'(32'hFFFF_FFFF);

  logic [N-1:0] lvl_q, en_q, pend_q, edge_q, model_q;
  logic [N-1:0] en_n, pend_n, edge_n, model_n;
  logic [N-1:0] ack_oh, eoi_oh, rise, set_v, clr_v, en_set_eff, en_clr_eff;

  assign ack_oh     = ack_vld ? (N'(1) << ack_id) : '0;
  assign eoi_oh     = eoi_vld ? (N'(1) << eoi_id) : '0;
  assign rise       = irq_in & ~lvl_q;
  assign en_set_eff = en_set_vld ? (en_set_mask & ~FIXED) : '0;
  assign en_clr_eff = en_clr_vld ? (en_clr_mask & ~FIXED) : '0;

  assign en_n    = (en_q & ~en_clr_eff) | en_set_eff;
  assign edge_n  = cfg_wr_vld ? ((edge_q & ~cfg_wr_mask) |
                                 (cfg_wr_mask & ({N{cfg_wr_val[1]}} | LOW32))) : edge_q;
  assign model_n = cfg_wr_vld ? ((model_q & ~cfg_wr_mask) |
                                 (cfg_wr_mask & {N{cfg_wr_val[0]}})) : model_q;

  assign clr_v = ack_oh | (pend_clr_vld ? pend_clr_mask : '0);
  assign set_v = (pend_set_vld ? pend_set_mask : '0)
               | (en_set_eff & ~edge_n & lvl_q)
               | (eoi_oh & ~edge_n & en_n & lvl_q)
               | (rise & (edge_n | en_n));
  assign pend_n = (pend_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      en_q    <= FIXED;
      pend_q  <= '0;
      edge_q  <= FIXED;
      model_q <= '0;
    end else begin
      lvl_q   <= irq_in;
      en_q    <= en_n;
      pend_q  <= pend_n;
      edge_q  <= edge_n;
      model_q <= model_n;
    end
  end

  assign en_vec    = en_q;
  assign pend_vec  = pend_q;
  assign edge_vec  = edge_q;
  assign model_vec = model_q;

  a_r2_edge_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_vld && !pend_clr_vld && !cfg_wr_vld)
    |=> ((pend_q & $past(irq_in & ~lvl_q & edge_q)) == $past(irq_in & ~lvl_q & edge_q)));

  a_r4_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_vld && !pend_clr_vld) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_id < ID_W'(N) && !pend_set_vld && !en_set_vld && !eoi_vld && irq_in == lvl_q)
    |=> !pend_q[$past(ack_id)]);

  a_r10_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr_vld && !pend_set_vld && !en_set_vld && !eoi_vld && (irq_in & ~lvl_q) == '0)
    |=> ((pend_q & $past(pend_clr_mask)) == '0));

  a_r8_low_ids_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_vld) |=> ((en_q & FIXED) == FIXED));
endmodule

// File: tb/irq_pend_track_tb_top.sv
`timescale 1ns/1ps
module irq_pend_track_tb_top;
  localparam int N = 64;
  localparam int ID_W = 10;
  localparam logic [N-1:0] FIXED = 64'h0000_0000_0000_FFFF;
  localparam logic [N-1:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic en_set_vld = 0, en_clr_vld = 0, pend_set_vld = 0, pend_clr_vld = 0, cfg_wr_vld = 0;
  logic [N-1:0] en_set_mask = '0, en_clr_mask = '0, pend_set_mask = '0, pend_clr_mask = '0, cfg_wr_mask = '0;
  logic [1:0] cfg_wr_val = '0;
  logic ack_vld = 0, eoi_vld = 0;
  logic [ID_W-1:0] ack_id = '0, eoi_id = '0;
  logic [N-1:0] en_vec, pend_vec, edge_vec, model_vec;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] m_lvl, m_en, m_pend, m_edge, m_model;

  always #10 clk = ~clk;

  irq_pend_track #(.N(N), .ID_W(ID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .en_set_vld(en_set_vld), .en_set_mask(en_set_mask),
    .en_clr_vld(en_clr_vld), .en_clr_mask(en_clr_mask),
    .pend_set_vld(pend_set_vld), .pend_set_mask(pend_set_mask),
    .pend_clr_vld(pend_clr_vld), .pend_clr_mask(pend_clr_mask),
    .cfg_wr_vld(cfg_wr_vld), .cfg_wr_mask(cfg_wr_mask), .cfg_wr_val(cfg_wr_val),
    .ack_vld(ack_vld), .ack_id(ack_id), .eoi_vld(eoi_vld), .eoi_id(eoi_id),
    .en_vec(en_vec), .pend_vec(pend_vec), .edge_vec(edge_vec), .model_vec(model_vec));

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] oh(logic [ID_W-1:0] id);
    return (id < N) ? (64'd1 << id) : '0;
  endfunction

  task automatic model_step();
    logic [N-1:0] en_n, edge_n, set_v, clr_v, es;
    es = en_set_vld ? en_set_mask & ~FIXED : '0;
    en_n = m_en;
    if (en_clr_vld) en_n = en_n & ~(en_clr_mask & ~FIXED);
    en_n = en_n | es;
    edge_n = m_edge;
    if (cfg_wr_vld) begin
      for (int i = 0; i < N; i++)
        if (cfg_wr_mask[i]) begin
          edge_n[i] = cfg_wr_val[1] | (i < 32);
          m_model[i] = cfg_wr_val[0];
        end
    end
    clr_v = (ack_vld ? oh(ack_id) : '0) | (pend_clr_vld ? pend_clr_mask : '0);
    set_v = pend_set_vld ? pend_set_mask : '0;
    for (int i = 0; i < N; i++) begin
      if (es[i] && !edge_n[i] && m_lvl[i]) set_v[i] = 1'b1;
      if (eoi_vld && eoi_id == i && !edge_n[i] && en_n[i] && m_lvl[i]) set_v[i] = 1'b1;
      if (irq_in[i] && !m_lvl[i] && (edge_n[i] || en_n[i])) set_v[i] = 1'b1;
    end
    m_pend = (m_pend & ~clr_v) | set_v;
    m_en = en_n; m_edge = edge_n; m_lvl = irq_in;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    en_set_vld = 0; en_clr_vld = 0; pend_set_vld = 0; pend_clr_vld = 0;
    cfg_wr_vld = 0; ack_vld = 0; eoi_vld = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_lvl = '0; m_en = FIXED; m_pend = '0; m_edge = FIXED; m_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en", en_vec, FIXED);
    chk("R1 edge", edge_vec, FIXED);
    chk("R1 pend", pend_vec, '0);
    chk("R1 model", model_vec, '0);

    cfg_wr_vld = 1; cfg_wr_mask = (64'd1 << 20) | (64'd1 << 41); cfg_wr_val = 2'b11; tick();
    chk("R7 edge", edge_vec & ((64'd1 << 20) | (64'd1 << 41) | (64'd1 << 40)), (64'd1 << 20) | (64'd1 << 41));
    chk("R7 model", model_vec, (64'd1 << 20) | (64'd1 << 41));
    cfg_wr_vld = 1; cfg_wr_mask = 64'd1 << 20; cfg_wr_val = 2'b00; tick();
    chk("R7 forced edge below 32", {63'd0, edge_vec[20]}, 64'd1);

    irq_in[40] = 1; tick();
    chk("R3 disabled level rise", {63'd0, pend_vec[40]}, 64'd0);
    irq_in[40] = 0; tick();
    irq_in[41] = 1; tick();
    chk("R2 edge rise while disabled", {63'd0, pend_vec[41]}, 64'd1);
    irq_in[41] = 0; tick();
    chk("R4 fall keeps pending", {63'd0, pend_vec[41]}, 64'd1);
    tick();
    chk("R4 steady level no change", pend_vec, 64'd1 << 41);
    ack_vld = 1; ack_id = 41; tick();
    chk("R9 ack edge line", {63'd0, pend_vec[41]}, 64'd0);

    irq_in[40] = 1; tick();
    chk("R3 still disabled", {63'd0, pend_vec[40]}, 64'd0);
    en_set_vld = 1; en_set_mask = 64'd1 << 40; tick();
    chk("R5 enable while high", {63'd0, pend_vec[40]}, 64'd1);
    ack_vld = 1; ack_id = 40; tick();
    chk("R9 ack level line", {63'd0, pend_vec[40]}, 64'd0);
    eoi_vld = 1; eoi_id = 40; tick();
    chk("R6 eoi while high", {63'd0, pend_vec[40]}, 64'd1);
    ack_vld = 1; ack_id = 40; irq_in[40] = 0; tick();
    eoi_vld = 1; eoi_id = 40; tick();
    chk("R6 eoi while low", {63'd0, pend_vec[40]}, 64'd0);
    eoi_vld = 1; eoi_id = 10'd1023; tick();
    chk("R6 out-of-range eoi", pend_vec, '0);

    en_clr_vld = 1; en_clr_mask = '1; tick();
    chk("R8 clear-enable ignored low", en_vec, FIXED);
    en_set_vld = 1; en_set_mask = 64'h0000_0000_0000_00F0; tick();
    chk("R8 set-enable ignored low", en_vec, FIXED);

    pend_set_vld = 1; pend_set_mask = 64'h00F0_0000_0000_0F00; tick();
    chk("R10 set-pending", pend_vec, 64'h00F0_0000_0000_0F00);
    pend_clr_vld = 1; pend_clr_mask = 64'h0010_0000_0000_0300; tick();
    chk("R10 clear-pending", pend_vec, 64'h00E0_0000_0000_0C00);

    pend_set_vld = 1; pend_set_mask = 64'd1 << 50;
    pend_clr_vld = 1; pend_clr_mask = 64'd1 << 50; tick();
    chk("R11 set beats clear", {63'd0, pend_vec[50]}, 64'd1);
    pend_set_vld = 1; pend_set_mask = 64'd1 << 50; ack_vld = 1; ack_id = 50; tick();
    chk("R11 set beats ack", {63'd0, pend_vec[50]}, 64'd1);
    cfg_wr_vld = 1; cfg_wr_mask = 64'd1 << 45; cfg_wr_val = 2'b10; irq_in[45] = 1; tick();
    chk("R11 rise uses new edge", {63'd0, pend_vec[45]}, 64'd1);
    chk("R11 model agrees", pend_vec, m_pend);

    void'($urandom(32'd4242));
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      irq_in = irq_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      en_set_vld = r[0] & r[1]; en_set_mask = {$urandom, $urandom};
      en_clr_vld = r[2] & r[3]; en_clr_mask = {$urandom, $urandom};
      pend_set_vld = r[4] & r[5] & r[6]; pend_set_mask = {$urandom, $urandom} & {$urandom, $urandom};
      pend_clr_vld = r[7] & r[8]; pend_clr_mask = {$urandom, $urandom};
      cfg_wr_vld = r[9] & r[10] & r[11]; cfg_wr_mask = {$urandom, $urandom}; cfg_wr_val = r[13:12];
      ack_vld = r[14]; ack_id = ID_W'($urandom_range(0, 70));
      eoi_vld = r[15]; eoi_id = ID_W'($urandom_range(0, 70));
      tick();
      chk("R10 random pend", pend_vec, m_pend);
      if (c % 50 == 0) begin
        chk("R8 random en", en_vec, m_en);
        chk("R7 random edge", edge_vec, m_edge);
        chk("R7 random model", model_vec, m_model);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule